// File: doc/BRIEF.md
# SDLC Loop Secondary Repeater

This block sits in the serial path of one secondary station on an SDLC loop. Bits arrive on `rxd` and leave on `txd`, one per cycle in which `bit_en` is high. The block watches the received stream for the end-of-poll pattern and for the flag pattern. It decides whether received bits pass straight through with no register in the path, or pass through a single one-bit delay stage. When the local host wants to send, the block rewrites the final bit of a passing end-of-poll so that it becomes a flag. It then sends a flag of its own and hands the output to a local bit source.

The host enables loop operation with `loop_en`. It requests a transmission by holding `go_active`, and it leaves the loop by pulsing `go_off`. The block joins and leaves the loop only at an end-of-poll boundary. After it joins, it must see a flag followed by another end-of-poll before it may transmit. The local source supplies one bit per `tx_pull` strobe. It closes its message with an end-of-poll, and the block then returns to echoing the delayed received stream.

Top module: `sdlc_loop_repeater`

## Requirements
- R1: After synchronous reset, `on_loop`, `loop_sending` and `eop_seen` are 0, and `txd` follows `rxd` combinationally.
- R2: Bit windows are read in line order, oldest bit first. An end-of-poll is a 0 followed by seven 1s. A flag is a 0, then six 1s, then a 0. A pattern is recognised at the `bit_en` edge that samples its final bit.
- R3: While the station is off the loop, `txd` equals `rxd` with no register in the path. With `loop_en` low, an end-of-poll changes neither `on_loop` nor `eop_seen`.
- R4: The first end-of-poll after `loop_en` is set makes `on_loop` 1 and raises `eop_seen` for exactly one clock. From then on, each received bit appears on `txd` after the `bit_en` edge that sampled it and holds until the next such edge.
- R5: An end-of-poll that arrives after joining, but before any flag has been seen, does not start a transmission, even with `go_active` high. That end-of-poll is echoed unchanged.
- R6: Once a flag has been seen, an end-of-poll with `go_active` high is repeated with its final bit forced to 0, and `loop_sending` becomes 1 at that same edge.
- R7: After the rewritten bit, the block outputs one complete flag, one bit per `bit_en`. It then outputs local bits. Each local bit appears on `txd` after the `bit_en` edge at which `tx_pull` is high, and `tx_pull` is high only at those edges.
- R8: When the local bits form an end-of-poll, `loop_sending` clears at the edge that outputs its final bit. Echo of the delayed receive stream resumes on the next bit. A further flag is needed before the station may send again.
- R9: With a flag seen but `go_active` low, an end-of-poll is echoed unchanged, and `loop_sending` stays 0.
- R10: After `go_off`, the one-bit delay stays in place until the next received end-of-poll. At that edge `on_loop` clears, `eop_seen` pulses, and `txd` again follows `rxd` combinationally.
- R11: Dropping `loop_en` returns the block to combinational pass-through at the next clock, with `on_loop` and `loop_sending` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-time strobe; one bit moves per high cycle |
| rxd | input | 1 | Received serial bit |
| loop_en | input | 1 | Enable loop operation |
| go_active | input | 1 | Request to seize the next eligible end-of-poll |
| go_off | input | 1 | Request to leave the loop at the next end-of-poll |
| tx_bit | input | 1 | Next bit from the local message source |
| tx_pull | output | 1 | Strobe: `tx_bit` is consumed this cycle |
| txd | output | 1 | Transmitted serial bit |
| on_loop | output | 1 | The one-bit delay is inserted |
| loop_sending | output | 1 | The output carries local bits |
| eop_seen | output | 1 | One-clock pulse per received end-of-poll while enabled |

## Verification
The assertions assume that `bit_en` is a strobe and that `rxd` and `tx_bit` change only between strobes. They also assume that the local source ends every message with an end-of-poll. The bench keeps to these assumptions. It raises `bit_en` for one clock out of every four, and it changes the serial inputs only on falling edges with the strobe low. Its only local message is a data byte followed by an end-of-poll. The received stream keeps `go_off` apart from any transmission in progress, and its idle runs of 1s are never long enough to form a false pattern.

// File: rtl/sdlc_loop_pkg.sv
package sdlc_loop_pkg;

  typedef enum logic [2:0] {
    LS_PASS      = 3'd0,  // off the loop, combinational pass-through
    LS_WAIT_FLAG = 3'd1,  // on the loop, waiting for a flag
    LS_ARMED     = 3'd2,  // flag seen, next poll may be taken
    LS_LEAD_FLAG = 3'd3,  // emitting the leading flag
    LS_LOCAL     = 3'd4   // emitting local source bits
  } loop_state_e;

endpackage

// File: rtl/sdlc_pattern_window.sv
module sdlc_pattern_window #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_PAT = 1,
  parameter logic [N_PAT*W-1:0] PATS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             din,
  output logic [N_PAT-1:0] hit
);
  // Window index 0 holds the oldest bit in line order.
  logic [W-1:0] win_q;
  logic [W-1:0] win_nxt;

  assign win_nxt = {din, win_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_q <= '1;  // all ones: no pattern can match before a real zero
    end else if (adv) begin
      win_q <= win_nxt;
    end
  end

  for (genvar p = 0; p < N_PAT; p++) begin : g_match
    assign hit[p] = adv && (win_nxt == PATS[p*W +: W]);
  end

endmodule

// File: rtl/sdlc_loop_ctrl.sv
module sdlc_loop_ctrl
  import sdlc_loop_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             loop_en,
  input  logic             go_active,
  input  logic             go_off,
  input  logic             rx_eop,
  input  logic             rx_flag,
  input  logic             tx_eop,
  output loop_state_e      state_q,
  output logic [IDX_W-1:0] lead_idx_q,
  output logic             convert,
  output logic             on_loop_q,
  output logic             sending_q,
  output logic             eop_seen_q
);
  loop_state_e state_nxt;
  logic        off_pend_q;

  always_comb begin
    state_nxt = state_q;
    convert   = 1'b0;
    if (!loop_en) begin
      state_nxt = LS_PASS;
    end else if (bit_en) begin
      unique case (state_q)
        LS_PASS: begin
          if (rx_eop) state_nxt = LS_WAIT_FLAG;
        end
        LS_WAIT_FLAG: begin
          if (rx_eop && off_pend_q) state_nxt = LS_PASS;
          else if (rx_flag)         state_nxt = LS_ARMED;
        end
        LS_ARMED: begin
          if (rx_eop) begin
            if (off_pend_q) begin
              state_nxt = LS_PASS;
            end else if (go_active) begin
              state_nxt = LS_LEAD_FLAG;
              convert   = 1'b1;
            end
          end
        end
        LS_LEAD_FLAG: begin
          if (lead_idx_q == IDX_W'(W - 1)) state_nxt = LS_LOCAL;
        end
        LS_LOCAL: begin
          if (tx_eop) state_nxt = LS_WAIT_FLAG;
        end
        default: state_nxt = LS_PASS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= LS_PASS;
      off_pend_q <= 1'b0;
      lead_idx_q <= '0;
      on_loop_q  <= 1'b0;
      sending_q  <= 1'b0;
      eop_seen_q <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (state_nxt == LS_PASS) off_pend_q <= 1'b0;
      else if (go_off && state_q != LS_PASS) off_pend_q <= 1'b1;
      if (state_q != LS_LEAD_FLAG) lead_idx_q <= '0;
      else if (bit_en) lead_idx_q <= lead_idx_q + IDX_W'(1);
      on_loop_q  <= (state_nxt != LS_PASS);
      sending_q  <= (state_nxt == LS_LEAD_FLAG) || (state_nxt == LS_LOCAL);
      eop_seen_q <= loop_en && rx_eop;
    end
  end

endmodule

// File: rtl/sdlc_loop_outpath.sv
module sdlc_loop_outpath
  import sdlc_loop_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W),
  parameter logic [W-1:0] FLAG_PAT = 8'b0111_1110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             rxd,
  input  logic             tx_bit,
  input  loop_state_e      state_q,
  input  logic             convert,
  input  logic [IDX_W-1:0] lead_idx_q,
  output logic             txd,
  output logic             tx_pull
);
  logic stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= 1'b1;
    end else if (bit_en) begin
      if (convert) begin
        stage_q <= 1'b0;  // final bit of the poll becomes the flag's closing zero
      end else begin
        unique case (state_q)
          LS_LEAD_FLAG: stage_q <= FLAG_PAT[lead_idx_q];
          LS_LOCAL:     stage_q <= tx_bit;
          default:      stage_q <= rxd;
        endcase
      end
    end
  end

  assign txd     = (state_q == LS_PASS) ? rxd : stage_q;
  assign tx_pull = bit_en && (state_q == LS_LOCAL);

endmodule

// File: rtl/sdlc_loop_repeater.sv
module sdlc_loop_repeater
  import sdlc_loop_pkg::*;
#(
  parameter int unsigned FRAME_W = 8,
  parameter logic [FRAME_W-1:0] EOP_PAT  = 8'b1111_1110,
  parameter logic [FRAME_W-1:0] FLAG_PAT = 8'b0111_1110
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rxd,
  input  logic loop_en,
  input  logic go_active,
  input  logic go_off,
  input  logic tx_bit,
  output logic tx_pull,
  output logic txd,
  output logic on_loop,
  output logic loop_sending,
  output logic eop_seen
);
  localparam int unsigned IDX_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  loop_state_e      state_q;
  logic [IDX_W-1:0] lead_idx_q;
  logic             convert;
  logic [1:0]       rx_hit;
  logic [0:0]       tx_hit;
  logic             tx_win_clr;

  assign tx_win_clr = (state_q != LS_LOCAL);

  sdlc_pattern_window #(
    .W(FRAME_W), .N_PAT(2), .PATS({FLAG_PAT, EOP_PAT})
  ) u_rx_win (
    .clk(clk), .rst(rst), .clr(1'b0), .adv(bit_en), .din(rxd), .hit(rx_hit)
  );

  sdlc_pattern_window #(
    .W(FRAME_W), .N_PAT(1), .PATS(EOP_PAT)
  ) u_tx_win (
    .clk(clk), .rst(rst), .clr(tx_win_clr), .adv(tx_pull), .din(tx_bit), .hit(tx_hit)
  );

  sdlc_loop_ctrl #(.W(FRAME_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .loop_en(loop_en),
    .go_active(go_active), .go_off(go_off),
    .rx_eop(rx_hit[0]), .rx_flag(rx_hit[1]), .tx_eop(tx_hit[0]),
    .state_q(state_q), .lead_idx_q(lead_idx_q), .convert(convert),
    .on_loop_q(on_loop), .sending_q(loop_sending), .eop_seen_q(eop_seen)
  );

  sdlc_loop_outpath #(.W(FRAME_W), .IDX_W(IDX_W), .FLAG_PAT(FLAG_PAT)) u_out (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rxd(rxd), .tx_bit(tx_bit),
    .state_q(state_q), .convert(convert), .lead_idx_q(lead_idx_q),
    .txd(txd), .tx_pull(tx_pull)
  );

endmodule

// File: rtl/sdlc_loop_repeater_chk.sv
module sdlc_loop_repeater_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic rxd,
  input logic loop_en,
  input logic tx_pull,
  input logic txd,
  input logic on_loop,
  input logic loop_sending,
  input logic eop_seen
);
  AST_PASS_TRACKS_RX: assert property (@(posedge clk) disable iff (rst)
    !on_loop |-> (txd == rxd)); // R3

  AST_JOIN_AT_POLL: assert property (@(posedge clk) disable iff (rst)
    $rose(on_loop) |-> eop_seen); // R4

  AST_POLL_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eop_seen |=> !eop_seen); // R4

  AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (on_loop && loop_en && !bit_en) |=> $stable(txd)); // R4

  AST_GRAB_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(loop_sending) |-> (!txd && $past(bit_en))); // R6

  AST_SEND_ON_LOOP: assert property (@(posedge clk) disable iff (rst)
    loop_sending |-> on_loop); // R6

  AST_PULL_IN_SEND: assert property (@(posedge clk) disable iff (rst)
    tx_pull |-> (loop_sending && bit_en)); // R7

  AST_LEAVE_AT_POLL: assert property (@(posedge clk) disable iff (rst)
    $fell(on_loop) |-> (eop_seen || !$past(loop_en))); // R10

endmodule

bind sdlc_loop_repeater sdlc_loop_repeater_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .rxd(rxd), .loop_en(loop_en),
  .tx_pull(tx_pull), .txd(txd), .on_loop(on_loop),
  .loop_sending(loop_sending), .eop_seen(eop_seen)
);

// File: tb/sdlc_loop_repeater_bench.sv
module sdlc_loop_repeater_bench;
  localparam logic [7:0] EOP  = 8'b1111_1110;  // index 0 first on the line
  localparam logic [7:0] FLAG = 8'b0111_1110;
  localparam logic [15:0] MSG = {EOP, 8'hA5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, rxd = 1'b1, loop_en = 1'b0, go_active = 1'b0, go_off = 1'b0;
  logic tx_bit = 1'b1;
  logic tx_pull, txd, on_loop, loop_sending, eop_seen;

  int checks = 0, errors = 0, idx = 0, npull = 0;
  logic s_txd, s_on, s_snd, s_eop, s_eop2, pulled;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdlc_loop_repeater u_sdlc_loop_repeater (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rxd(rxd), .loop_en(loop_en),
    .go_active(go_active), .go_off(go_off), .tx_bit(tx_bit), .tx_pull(tx_pull),
    .txd(txd), .on_loop(on_loop), .loop_sending(loop_sending), .eop_seen(eop_seen)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rxd = b;
    tx_bit = (idx < 16) ? MSG[idx] : 1'b1;
    bit_en = 1'b1;
    #1 pulled = tx_pull;
    @(negedge clk);
    bit_en = 1'b0;
    #1;
    s_txd = txd; s_on = on_loop; s_snd = loop_sending; s_eop = eop_seen;
    if (pulled) begin idx++; npull++; end
    @(negedge clk);
    #1 s_eop2 = eop_seen;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic t_reset;
    chk("R1 on_loop", on_loop, 1'b0);
    chk("R1 loop_sending", loop_sending, 1'b0);
    chk("R1 eop_seen", eop_seen, 1'b0);
    rxd = 1'b0; #1 chk("R1 txd follows rxd 0", txd, 1'b0);
    rxd = 1'b1; #1 chk("R1 txd follows rxd 1", txd, 1'b1);
  endtask

  task automatic t_disabled;
    send_byte(EOP);
    chk("R3 disabled on_loop", s_on, 1'b0);
    chk("R3 disabled eop_seen", s_eop, 1'b0);
  endtask

  task automatic t_join;
    loop_en = 1'b1;
    send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < 7; i++) send_bit(EOP[i]);
    @(negedge clk); rxd = 1'b0; #1 chk("R3 comb pass before join", txd, 1'b0);
    send_bit(1'b1);
    chk("R4 on_loop after first poll", s_on, 1'b1);
    chk("R4 eop_seen pulse", s_eop, 1'b1);
    chk("R4 eop_seen single cycle", s_eop2, 1'b0);
    chk("R2 poll recognised at final bit", s_txd, 1'b1);
    send_bit(1'b0);
    chk("R4 delayed bit 0", s_txd, 1'b0);
    rxd = 1'b1;
    @(negedge clk); #1 chk("R4 delay stage holds", txd, 1'b0);
    send_bit(1'b1);
    chk("R4 delayed bit 1", s_txd, 1'b1);
  endtask

  task automatic t_early_poll;
    go_active = 1'b1;
    send_byte(EOP);
    chk("R5 no send before flag", s_snd, 1'b0);
    chk("R5 poll echoed", s_txd, 1'b1);
  endtask

  task automatic t_grab;
    send_byte(FLAG);
    send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < 7; i++) send_bit(EOP[i]);
    idx = 0; npull = 0;
    send_bit(1'b1);
    chk("R6 loop_sending set", s_snd, 1'b1);
    chk("R6 final poll bit forced 0", s_txd, 1'b0);
    for (int k = 0; k < 8; k++) begin
      send_bit(1'b1);
      chk("R7 leading flag bit", s_txd, FLAG[k]);
    end
    chk_int("R7 no pull during flag", npull, 0);
    for (int k = 0; k < 16; k++) begin
      send_bit(1'b1);
      chk("R7 local bit", s_txd, MSG[k]);
      if (k == 14) chk("R8 still sending", s_snd, 1'b1);
    end
    chk("R8 sending cleared at closing poll", s_snd, 1'b0);
    chk_int("R7 pull count", npull, 16);
    send_bit(1'b0);
    chk("R8 echo resumes", s_txd, 1'b0);
    chk("R8 still on loop", s_on, 1'b1);
    send_byte(EOP);
    chk("R8 needs new flag", s_snd, 1'b0);
    go_active = 1'b0;
  endtask

  task automatic t_idle_pass;
    send_byte(FLAG);
    send_bit(1'b1);
    send_byte(EOP);
    chk("R9 no send without request", s_snd, 1'b0);
    chk("R9 poll echoed", s_txd, 1'b1);
    chk("R9 on loop", s_on, 1'b1);
  endtask

  task automatic t_off;
    @(negedge clk); go_off = 1'b1;
    @(negedge clk); go_off = 1'b0;
    send_bit(1'b0);
    chk("R10 still on loop", s_on, 1'b1);
    rxd = 1'b1;
    @(negedge clk); #1 chk("R10 delay kept", txd, 1'b0);
    send_byte(EOP);
    chk("R10 off at poll", s_on, 1'b0);
    chk("R10 eop_seen pulse", s_eop, 1'b1);
    rxd = 1'b0; #1 chk("R10 pass-through 0", txd, 1'b0);
    rxd = 1'b1; #1 chk("R10 pass-through 1", txd, 1'b1);
  endtask

  task automatic t_disable_on_loop;
    send_bit(1'b0);
    send_byte(EOP);
    chk("R11 rejoined", s_on, 1'b1);
    @(negedge clk); loop_en = 1'b0;
    @(negedge clk); #1;
    chk("R11 on_loop cleared", on_loop, 1'b0);
    chk("R11 sending clear", loop_sending, 1'b0);
    rxd = 1'b0; #1 chk("R11 pass-through", txd, 1'b0);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_join;
    t_early_poll;
    t_grab;
    t_idle_pass;
    t_off;
    t_disable_on_loop;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule